// File: doc/BRIEF.md
# Boot Strap Configuration and Diagnostic LED Registers

This block puts two registers on a 32-bit processor-side bus. The bus uses a request/acknowledge handshake and byte enables. One register is read-only. It reports the levels of eight board strap pins: a halt-enable flag, a three-bit baud-rate select, a two-bit CPU code and a two-bit boot/diagnostic code. Boot firmware reads these straps to choose a start-up path. The other register holds four bits that drive an active-low diagnostic LED display. Writing 0 to a bit lights its LED, and writing 1 turns it off.

The strap pins, the DC-OK power signal and the halted-status input all enter through a two-flop synchronizer. The LED bits clear, so every lamp is lit, in two cases: at reset, and when DC-OK falls while the processor is halted. This gives a lamp test at power events.

The bus engine is a two-state machine:
- BUS_IDLE waits for a request. When a request arrives it captures the read data, applies any LED write and moves to BUS_ACK.
- BUS_ACK drives the acknowledge for one cycle and always returns to BUS_IDLE.

Top module: `boot_cfg_led_regs`

## Requirements
- R1: While reset is held and in the first cycle after it, `ack` is 0, `rdata` is 0 and `led_n` is 4'b0000 (all LEDs lit).
- R2: A request sampled in BUS_IDLE is answered by `ack` high in the next cycle. `ack` is high for exactly one cycle, and a request seen while `ack` is high is not a new access.
- R3: A read of address 0x2008_4004 returns the strap levels as follows: bit 7 is `halt_en_pin`, bits 6:4 are `baud_sel`, bits 3:2 are `cpu_code` and bits 1:0 are `boot_code`. Bits 31:8 read 0.
- R4: A strap change becomes visible to reads two clock edges after it occurs. A read accepted three or more edges after the change reports the new value.
- R5: A write to 0x2008_4004, with any byte enables, changes neither the value read back nor `led_n`.
- R6: A write to 0x2014_0030 with `be[0]`=1 sets `led_n` to `wdata[3:0]` at the edge that raises `ack`. A read of that address returns `led_n` in bits 3:0 and 0 in bits 31:4.
- R7: A write to 0x2014_0030 with `be[0]`=0 leaves `led_n` unchanged.
- R8: A fall of `dc_ok` while `cpu_halted` is 1 clears `led_n` to 0000 on the third edge after the fall. A fall of `dc_ok` while `cpu_halted` is 0 leaves `led_n` unchanged.
- R9: An access to any other address is acknowledged. A read there returns 0, and a write there has no effect.
- R10: If a lamp-test clear and an LED write land on the same edge, the clear wins and `led_n` becomes 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables |
| ack | output | 1 | Access complete, one-cycle pulse |
| rdata | output | 32 | Read data, valid while ack is high |
| halt_en_pin | input | 1 | Halt-enable strap |
| baud_sel | input | 3 | Baud-rate select straps |
| cpu_code | input | 2 | CPU code straps |
| boot_code | input | 2 | Boot/diagnostic mode straps |
| dc_ok | input | 1 | DC power good |
| cpu_halted | input | 1 | Processor is halted |
| led_n | output | 4 | LED drive, 0 = lit |

## Verification
The bench raises a request on a falling edge. After exactly one rising edge it samples `ack`, `rdata` and the freshly written `led_n` on the next falling edge. It then confirms on the following falling edge that `ack` has dropped.

After each strap change the bench lets three rising edges pass before it starts a read. This covers the two synchronizer stages and gives one edge of margin.

For the lamp test, `led_n` is checked on the falling edge after the third rising edge that follows the `dc_ok` fall. The collision case for R10 is timed so that the write is accepted on exactly that third edge.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned BE_W     = DATA_W / 8;
    localparam int unsigned STRAP_W  = 8;
    localparam int unsigned LED_W    = 4;
    localparam logic [ADDR_W-1:0] CFG_ADDR = 32'h2008_4004;
    localparam logic [ADDR_W-1:0] LED_ADDR = 32'h2014_0030;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;
endpackage

// File: rtl/bcl_sync.sv
module bcl_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bcl_led_reg.sv
module bcl_led_reg #(
    parameter int unsigned LED_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dcok_s,
    input  logic             halt_s,
    input  logic             wr_en,
    input  logic [LED_W-1:0] wr_val,
    output logic             lamp_clr,
    output logic [LED_W-1:0] led_q
);
    logic dcok_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dcok_prev <= 1'b0;
        else        dcok_prev <= dcok_s;
    end

    assign lamp_clr = dcok_prev & ~dcok_s & halt_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        led_q <= '0;
        else if (lamp_clr) led_q <= '0;
        else if (wr_en)    led_q <= wr_val;
    end
endmodule

// File: rtl/bcl_bus_fsm.sv
module bcl_bus_fsm
    import bcl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LED_W-1:0]   wdata_lo,
    input  logic               be0,
    input  logic [STRAP_W-1:0] cfg_byte,
    input  logic [LED_W-1:0]   led_val,
    output logic               ack,
    output logic [DATA_W-1:0]  rdata,
    output logic               led_we,
    output logic [LED_W-1:0]   led_wval
);
    bus_state_e state, nxt;
    logic hit_cfg, hit_led, accept;
    logic [DATA_W-1:0] rd_mux;

    assign hit_cfg = (addr == CFG_ADDR);
    assign hit_led = (addr == LED_ADDR);

    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            BUS_IDLE: if (req) begin
                nxt    = BUS_ACK;
                accept = 1'b1;
            end
            BUS_ACK:  nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_cfg)      rd_mux[STRAP_W-1:0] = cfg_byte;
        else if (hit_led) rd_mux[LED_W-1:0]   = led_val;
        led_we   = accept & we & be0 & hit_led;
        led_wval = wdata_lo;
        ack      = (state == BUS_ACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (accept) rdata <= we ? '0 : rd_mux;
    end
endmodule

// File: rtl/boot_cfg_led_regs.sv
module boot_cfg_led_regs
    import bcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic              halt_en_pin,
    input  logic [2:0]        baud_sel,
    input  logic [1:0]        cpu_code,
    input  logic [1:0]        boot_code,
    input  logic              dc_ok,
    input  logic              cpu_halted,
    output logic [LED_W-1:0]  led_n
);
    localparam int unsigned SYNC_W = STRAP_W + 2;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic              led_we, lamp_clr;
    logic [LED_W-1:0]  led_wval;

    assign raw_in = {dc_ok, cpu_halted, halt_en_pin, baud_sel, cpu_code, boot_code};

    bcl_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
    );

    bcl_led_reg #(.LED_W(LED_W)) u_led (
        .clk(clk), .rst_n(rst_n),
        .dcok_s(sync_out[SYNC_W-1]), .halt_s(sync_out[SYNC_W-2]),
        .wr_en(led_we), .wr_val(led_wval),
        .lamp_clr(lamp_clr), .led_q(led_n)
    );

    bcl_bus_fsm u_bus (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata_lo(wdata[LED_W-1:0]), .be0(be[0]),
        .cfg_byte(sync_out[STRAP_W-1:0]), .led_val(led_n),
        .ack(ack), .rdata(rdata), .led_we(led_we), .led_wval(led_wval)
    );
endmodule

// File: rtl/bcl_checker.sv
module bcl_checker
    import bcl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [BE_W-1:0]   be,
    input logic              ack,
    input logic [DATA_W-1:0] rdata,
    input logic [LED_W-1:0]  led_n,
    input logic              lamp_clr
);
    logic led_wr;
    assign led_wr = req && !ack && we && be[0] && addr == LED_ADDR;

    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> ack);
    a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !ack) |=> !ack);
    a_r3_cfg_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !we && addr == CFG_ADDR) |=> rdata[DATA_W-1:STRAP_W] == '0);
    a_r6_led_write: assert property (@(posedge clk) disable iff (!rst_n)
        (led_wr && !lamp_clr) |=> led_n == $past(wdata[LED_W-1:0]));
    a_r6_led_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !we && addr == LED_ADDR) |=> rdata[DATA_W-1:LED_W] == '0);
    a_r7_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_wr && !lamp_clr) |=> $stable(led_n));
    a_r8_lamp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_clr |=> led_n == '0);
    a_r9_other_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && addr != CFG_ADDR && addr != LED_ADDR) |=> rdata == '0);
endmodule

bind boot_cfg_led_regs bcl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .be(be), .ack(ack), .rdata(rdata), .led_n(led_n), .lamp_clr(lamp_clr)
);

// File: tb/boot_cfg_led_regs_test.sv
module boot_cfg_led_regs_test;
    localparam logic [31:0] CFG_A = 32'h2008_4004;
    localparam logic [31:0] LED_A = 32'h2014_0030;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [3:0] be = '0;
    logic ack;
    logic [31:0] rdata;
    logic halt_en_pin = 1'b0;
    logic [2:0] baud_sel = '0;
    logic [1:0] cpu_code = '0, boot_code = '0;
    logic dc_ok = 1'b1, cpu_halted = 1'b0;
    logic [3:0] led_n;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    boot_cfg_led_regs uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .be(be), .ack(ack), .rdata(rdata), .halt_en_pin(halt_en_pin),
        .baud_sel(baud_sel), .cpu_code(cpu_code), .boot_code(boot_code),
        .dc_ok(dc_ok), .cpu_halted(cpu_halted), .led_n(led_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] b, output logic [31:0] r);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; be = b;
        @(negedge clk);
        req = 1'b0;
        check("R2 ack raised", {31'b0, ack}, 32'd1);
        r = rdata;
        @(negedge clk);
        check("R2 ack dropped", {31'b0, ack}, 32'd0);
    endtask

    task automatic set_straps(input logic [7:0] v);
        @(negedge clk);
        {halt_en_pin, baud_sel, cpu_code, boot_code} = v;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        logic [31:0] r;
        logic [3:0] led_exp;
        repeat (3) @(negedge clk);
        check("R1 ack in reset", {31'b0, ack}, 32'd0);
        check("R1 rdata in reset", rdata, 32'd0);
        check("R1 led in reset", {28'b0, led_n}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 led after reset", {28'b0, led_n}, 32'd0);
        check("R1 ack after reset", {31'b0, ack}, 32'd0);

        // R3 / R4: sweep all strap combinations
        for (int v = 0; v < 256; v++) begin
            set_straps(v[7:0]);
            access(1'b0, CFG_A, '0, 4'hF, r);
            check("R3 R4 strap read", r, {24'b0, v[7:0]});
        end

        // R6: all LED values
        for (int v = 0; v < 16; v++) begin
            access(1'b1, LED_A, {28'hFFFFFFF, v[3:0]}, 4'b0001, r);
            check("R6 led_n after write", {28'b0, led_n}, {28'b0, v[3:0]});
            access(1'b0, LED_A, '0, 4'hF, r);
            check("R6 led readback", r, {28'b0, v[3:0]});
        end
        led_exp = 4'hF;

        // R7: be[0]=0 writes ignored
        for (int b = 0; b < 16; b += 2) begin
            access(1'b1, LED_A, 32'h0, b[3:0], r);
            check("R7 led unchanged", {28'b0, led_n}, {28'b0, led_exp});
        end

        // R5: config writes ignored
        set_straps(8'hA5);
        for (int b = 0; b < 16; b++) begin
            access(1'b1, CFG_A, 32'h0000_005A, b[3:0], r);
            access(1'b0, CFG_A, '0, 4'hF, r);
            check("R5 cfg unchanged", r, 32'h0000_00A5);
            check("R5 led unchanged", {28'b0, led_n}, {28'b0, led_exp});
        end

        // R9: other addresses
        for (int k = 0; k < 6; k++) begin
            logic [31:0] oa;
            oa = (k < 3) ? CFG_A + 32'(4 * (k + 1)) : LED_A - 32'(4 * (k - 2));
            access(1'b1, oa, 32'h0, 4'hF, r);
            check("R9 write elsewhere", {28'b0, led_n}, {28'b0, led_exp});
            access(1'b0, oa, '0, 4'hF, r);
            check("R9 read elsewhere", r, 32'd0);
        end

        // R8: fall of dc_ok while not halted has no effect
        @(negedge clk); cpu_halted = 1'b0; repeat (3) @(posedge clk);
        @(negedge clk); dc_ok = 1'b0; repeat (5) @(posedge clk);
        @(negedge clk);
        check("R8 not halted no clear", {28'b0, led_n}, {28'b0, led_exp});
        dc_ok = 1'b1; cpu_halted = 1'b1; repeat (4) @(posedge clk);

        // R8: fall while halted clears on third edge
        @(negedge clk); dc_ok = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 not yet cleared", {28'b0, led_n}, {28'b0, led_exp});
        @(negedge clk);
        check("R8 lamp test clear", {28'b0, led_n}, 32'd0);
        dc_ok = 1'b1; repeat (4) @(posedge clk);

        // R10: clear collides with write
        access(1'b1, LED_A, 32'hF, 4'b0001, r);
        @(negedge clk); dc_ok = 1'b0;
        repeat (2) @(negedge clk);
        req = 1'b1; we = 1'b1; addr = LED_A; wdata = 32'h9; be = 4'b0001;
        @(negedge clk);
        req = 1'b0;
        check("R10 clear wins", {28'b0, led_n}, 32'd0);
        check("R2 ack on collision", {31'b0, ack}, 32'd1);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule